// File: doc/BRIEF.md
# Timer and External-Interrupt Control Register

This block is an 8-bit control register for an 8051-style microcontroller. It holds run enables and overflow flags for two timers, and request flags and trigger-type selects for two active-low external interrupt pins. Software reaches it in two ways. The first is a byte port decoded at a fixed address. The second is a single-bit write port, whose bit-address decode is done upstream, so `bit_wr_i` already means "this register".

Timers report overflow through one-cycle pulses. The interrupt controller returns one-cycle vector-acknowledge strobes, one per source. Each external pin passes through a synchronizer. In edge mode, the request flag latches on a falling edge. In level mode, the request flag is a live inverted copy of the synchronized pin.

Top module: `tcon_ctrl`

## Requirements
- R1: After reset all outputs are 0, and the byte read at the register address returns 0x00 while both pins are high.
- R2: Bit positions, from bit 7 down to bit 0, are: timer1 flag, timer1 run, timer0 flag, timer0 run, ext1 request, ext1 type, ext0 request, ext0 type. A byte read at address 0x88 returns these bits. Any other address reads 0x00.
- R3: An overflow pulse sets that timer's flag, and the flag is visible in the cycle after the pulse.
- R4: A timer flag is cleared by its acknowledge strobe or by a software write of 0. A same-cycle overflow wins over both.
- R5: A run bit written to 1 drives that timer's run output high, and written to 0 drives it low.
- R6: A bit write takes a 3-bit index and one data bit, and changes only the indexed bit.
- R7: With the type bit at 1 (edge mode), a falling pin edge sets the request three clock edges after the pin changes: two synchronizer flops, then the flag. A rising edge leaves the flag unchanged.
- R8: In edge mode the request is cleared by its acknowledge strobe or by a software write of 0. A same-cycle detected falling edge wins over both.
- R9: With the type bit at 0 (level mode), the request equals the inverted pin two clock edges after the pin changes. Acknowledge strobes and writes to the request bit have no effect on it.
- R10: Any edge-mode latch state is discarded while in level mode. Returning to edge mode with the pin high shows a request of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_wr_i | input | 1 | Byte write strobe |
| sfr_addr_i | input | 8 | Byte access address |
| sfr_wdata_i | input | 8 | Byte write data |
| sfr_rdata_o | output | 8 | Byte read data (0 when the address does not match) |
| bit_wr_i | input | 1 | Single-bit write strobe |
| bit_idx_i | input | 3 | Bit index for the single-bit write |
| bit_data_i | input | 1 | Single-bit write value |
| tmr_ovf_i | input | 2 | Overflow pulses, index = timer |
| tmr_ack_i | input | 2 | Timer vector acknowledge strobes |
| int_n_i | input | 2 | Raw active-low interrupt pins |
| ext_ack_i | input | 2 | External interrupt vector acknowledge strobes |
| tmr_run_o | output | 2 | Timer run enables |
| tmr_flag_o | output | 2 | Timer overflow flags |
| ext_req_o | output | 2 | External interrupt request flags |

## Verification
Two events can land on the same clock edge: a hardware set of a flag (a timer overflow pulse, or a detected falling edge) and its clearing (a vector acknowledge or a software write of 0). The bench first makes the flag 1. For a timer, it drives the overflow pulse, the acknowledge and a bit write of 0 in the same cycle. For a pin, it lowers the pin two edges before the acknowledge and write cycle, so the synchronized falling edge is detected exactly then. The flag must still read 1 afterwards, and a following lone acknowledge must clear it, which shows that the clear path works on its own.

// File: rtl/tcon_pkg.sv
package tcon_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned N_TMR  = 2;
  localparam int unsigned N_EXT  = 2;

  function automatic int unsigned type_pos(input int unsigned ch);
    return 2 * ch;
  endfunction
  function automatic int unsigned req_pos(input int unsigned ch);
    return 2 * ch + 1;
  endfunction
  function automatic int unsigned run_pos(input int unsigned t);
    return 4 + 2 * t;
  endfunction
  function automatic int unsigned flag_pos(input int unsigned t);
    return 5 + 2 * t;
  endfunction
endpackage

// File: rtl/tcon_pin_sync.sv
module tcon_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  output logic low_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_n_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign low_o  = ~sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];

  a_r7_fall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tcon_ext_req.sv
module tcon_ext_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  input  logic fall_i,
  input  logic type_wr_i,
  input  logic type_val_i,
  input  logic req_wr_i,
  input  logic req_val_i,
  input  logic ack_i,
  output logic type_o,
  output logic req_o
);
  logic type_q, latch_q, latch_d;

  always_comb begin
    latch_d = latch_q;
    if (!type_q)       latch_d = 1'b0;      // level mode: no stored state
    else if (fall_i)   latch_d = 1'b1;      // hardware set wins
    else if (req_wr_i) latch_d = req_val_i;
    else if (ack_i)    latch_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      if (type_wr_i) type_q <= type_val_i;
      latch_q <= latch_d;
    end
  end

  assign type_o = type_q;
  assign req_o  = type_q ? latch_q : low_i;

  a_r7_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_q && fall_i && !type_wr_i) |=> req_o);
  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_q && ack_i && !fall_i && !req_wr_i && !type_wr_i) |=> !req_o);
  a_r10_edge_reentry_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(type_q) |-> !req_o);
endmodule

// File: rtl/tcon_tmr_slice.sv
module tcon_tmr_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic ack_i,
  input  logic run_wr_i,
  input  logic run_val_i,
  input  logic flag_wr_i,
  input  logic flag_val_i,
  output logic run_o,
  output logic flag_o
);
  logic run_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (run_wr_i) run_q <= run_val_i;
      if (ovf_i)          flag_q <= 1'b1;
      else if (flag_wr_i) flag_q <= flag_val_i;
      else if (ack_i)     flag_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign flag_o = flag_q;

  a_r3_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_o);
  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ovf_i && !flag_wr_i) |=> !flag_o);
endmodule

// File: rtl/tcon_ctrl.sv
module tcon_ctrl
  import tcon_pkg::*;
#(
  parameter logic [7:0]  SFR_ADDR    = 8'h88,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sfr_wr_i,
  input  logic [7:0]          sfr_addr_i,
  input  logic [REG_W-1:0]    sfr_wdata_i,
  output logic [REG_W-1:0]    sfr_rdata_o,
  input  logic                bit_wr_i,
  input  logic [IDX_W-1:0]    bit_idx_i,
  input  logic                bit_data_i,
  input  logic [N_TMR-1:0]    tmr_ovf_i,
  input  logic [N_TMR-1:0]    tmr_ack_i,
  input  logic [N_EXT-1:0]    int_n_i,
  input  logic [N_EXT-1:0]    ext_ack_i,
  output logic [N_TMR-1:0]    tmr_run_o,
  output logic [N_TMR-1:0]    tmr_flag_o,
  output logic [N_EXT-1:0]    ext_req_o
);
  logic             byte_hit;
  logic [REG_W-1:0] wr_en, wr_val, view;
  logic [N_EXT-1:0] ext_type;

  assign byte_hit = sfr_wr_i && (sfr_addr_i == SFR_ADDR);

  for (genvar b = 0; b < REG_W; b++) begin : g_wr
    assign wr_en[b]  = byte_hit || (bit_wr_i && (bit_idx_i == IDX_W'(b)));
    assign wr_val[b] = byte_hit ? sfr_wdata_i[b] : bit_data_i;
  end

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    tcon_tmr_slice u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ovf_i      (tmr_ovf_i[t]),
      .ack_i      (tmr_ack_i[t]),
      .run_wr_i   (wr_en[run_pos(t)]),
      .run_val_i  (wr_val[run_pos(t)]),
      .flag_wr_i  (wr_en[flag_pos(t)]),
      .flag_val_i (wr_val[flag_pos(t)]),
      .run_o      (tmr_run_o[t]),
      .flag_o     (tmr_flag_o[t])
    );
    assign view[run_pos(t)]  = tmr_run_o[t];
    assign view[flag_pos(t)] = tmr_flag_o[t];
  end

  for (genvar c = 0; c < N_EXT; c++) begin : g_ext
    logic low, fall;
    tcon_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_n_i (int_n_i[c]),
      .low_o   (low),
      .fall_o  (fall)
    );
    tcon_ext_req u_req (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .low_i      (low),
      .fall_i     (fall),
      .type_wr_i  (wr_en[type_pos(c)]),
      .type_val_i (wr_val[type_pos(c)]),
      .req_wr_i   (wr_en[req_pos(c)]),
      .req_val_i  (wr_val[req_pos(c)]),
      .ack_i      (ext_ack_i[c]),
      .type_o     (ext_type[c]),
      .req_o      (ext_req_o[c])
    );
    assign view[type_pos(c)] = ext_type[c];
    assign view[req_pos(c)]  = ext_req_o[c];

    a_r9_level_ignores_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_type[c] && !wr_en[type_pos(c)]) |=> (ext_req_o[c] == low));
  end

  assign sfr_rdata_o = (sfr_addr_i == SFR_ADDR) ? view : '0;

  a_r6_bit_write_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_wr_i && !byte_hit && bit_idx_i != IDX_W'(run_pos(0)))
      |=> (tmr_run_o[0] == $past(tmr_run_o[0])));
endmodule

// File: tb/sim_tcon_ctrl.sv
`timescale 1ns/1ps
module sim_tcon_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h88;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       bit_wr = 1'b0;
  logic [2:0] bit_idx = 3'd0;
  logic       bit_data = 1'b0;
  logic [1:0] tmr_ovf = 2'b00, tmr_ack = 2'b00, int_n = 2'b11, ext_ack = 2'b00;
  logic [1:0] tmr_run, tmr_flag, ext_req;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tcon_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sfr_wr_i(sfr_wr), .sfr_addr_i(sfr_addr),
    .sfr_wdata_i(sfr_wdata), .sfr_rdata_o(sfr_rdata), .bit_wr_i(bit_wr),
    .bit_idx_i(bit_idx), .bit_data_i(bit_data), .tmr_ovf_i(tmr_ovf),
    .tmr_ack_i(tmr_ack), .int_n_i(int_n), .ext_ack_i(ext_ack),
    .tmr_run_o(tmr_run), .tmr_flag_o(tmr_flag), .ext_req_o(ext_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    sfr_wr = 1'b1; sfr_wdata = d; cyc(1); sfr_wr = 1'b0;
  endtask

  task automatic wr_bit(input logic [2:0] i, input logic d);
    bit_wr = 1'b1; bit_idx = i; bit_data = d; cyc(1); bit_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", sfr_rdata, 8'h00);
    chk("R1 outs", {2'b0, tmr_run, tmr_flag, ext_req}, 8'h00);
  endtask

  task automatic t_byte;
    wr_byte(8'h50);
    chk("R5 run both", {6'b0, tmr_run}, 8'h03);
    chk("R2 readback", sfr_rdata, 8'h50);
    sfr_addr = 8'h89; #0.1;
    chk("R2 other addr", sfr_rdata, 8'h00);
    sfr_addr = 8'h88;
    wr_byte(8'h00);
    chk("R5 run off", {6'b0, tmr_run}, 8'h00);
  endtask

  task automatic t_bit;
    wr_bit(3'd6, 1'b1);
    chk("R6 idx6", sfr_rdata, 8'h40);
    wr_bit(3'd4, 1'b1);
    chk("R6 idx4", sfr_rdata, 8'h50);
    wr_bit(3'd6, 1'b0);
    chk("R6 clr idx6", sfr_rdata, 8'h10);
    chk("R5 run0 only", {6'b0, tmr_run}, 8'h01);
    wr_byte(8'h00);
  endtask

  task automatic t_timer;
    tmr_ovf = 2'b01; cyc(1); tmr_ovf = 2'b00;
    chk("R3 flag0", {6'b0, tmr_flag}, 8'h01);
    chk("R2 flag0 pos", sfr_rdata, 8'h20);
    tmr_ack = 2'b01; cyc(1); tmr_ack = 2'b00;
    chk("R4 ack clr", {6'b0, tmr_flag}, 8'h00);
    tmr_ovf = 2'b10; cyc(1); tmr_ovf = 2'b00;
    chk("R3 flag1 pos", sfr_rdata, 8'h80);
    wr_bit(3'd7, 1'b0);
    chk("R4 sw clr", {6'b0, tmr_flag}, 8'h00);
    tmr_ovf = 2'b10; cyc(1); tmr_ovf = 2'b00;
    tmr_ovf = 2'b10; tmr_ack = 2'b10; bit_wr = 1'b1; bit_idx = 3'd7; bit_data = 1'b0;
    cyc(1);
    tmr_ovf = 2'b00; tmr_ack = 2'b00; bit_wr = 1'b0;
    chk("R4 set wins", {6'b0, tmr_flag}, 8'h02);
    tmr_ack = 2'b10; cyc(1); tmr_ack = 2'b00;
    chk("R4 ack alone", {6'b0, tmr_flag}, 8'h00);
  endtask

  task automatic t_level;
    int_n[0] = 1'b0; cyc(1);
    chk("R9 lag", {6'b0, ext_req}, 8'h00);
    cyc(1);
    chk("R9 follows", {6'b0, ext_req}, 8'h01);
    chk("R2 req0 pos", sfr_rdata, 8'h02);
    ext_ack = 2'b01; cyc(1); ext_ack = 2'b00;
    chk("R9 ack ignored", {6'b0, ext_req}, 8'h01);
    wr_byte(8'h00);
    chk("R9 write ignored", {6'b0, ext_req}, 8'h01);
    int_n[0] = 1'b1; cyc(2);
    chk("R9 release", {6'b0, ext_req}, 8'h00);
  endtask

  task automatic t_edge;
    wr_bit(3'd0, 1'b1);
    chk("R2 type0 pos", sfr_rdata, 8'h01);
    int_n[0] = 1'b0; cyc(2);
    chk("R7 not yet", {6'b0, ext_req}, 8'h00);
    cyc(1);
    chk("R7 set", sfr_rdata, 8'h03);
    int_n[0] = 1'b1; cyc(3);
    chk("R7 rise no effect", {6'b0, ext_req}, 8'h01);
    ext_ack = 2'b01; cyc(1); ext_ack = 2'b00;
    chk("R8 ack clr", {6'b0, ext_req}, 8'h00);
    int_n[0] = 1'b0; cyc(3); int_n[0] = 1'b1; cyc(3);
    wr_bit(3'd1, 1'b0);
    chk("R8 sw clr", {6'b0, ext_req}, 8'h00);
    int_n[0] = 1'b0; cyc(3); int_n[0] = 1'b1; cyc(3);
    chk("R7 reset again", {6'b0, ext_req}, 8'h01);
    int_n[0] = 1'b0; cyc(2);
    ext_ack = 2'b01; bit_wr = 1'b1; bit_idx = 3'd1; bit_data = 1'b0;
    cyc(1);
    ext_ack = 2'b00; bit_wr = 1'b0;
    chk("R8 edge wins", {6'b0, ext_req}, 8'h01);
    int_n[0] = 1'b1; cyc(3);
    wr_bit(3'd0, 1'b0);
    chk("R10 level view", {6'b0, ext_req}, 8'h00);
    wr_bit(3'd0, 1'b1);
    chk("R10 latch dropped", sfr_rdata, 8'h01);
    wr_bit(3'd2, 1'b1);
    int_n[1] = 1'b0; cyc(3);
    chk("R7 ch1", {6'b0, ext_req}, 8'h02);
    int_n[1] = 1'b1;
    wr_byte(8'h00); cyc(3);
    chk("R1 clean", sfr_rdata, 8'h00);
  endtask

  initial begin
    cyc(3); rst_ni = 1'b1; cyc(1);
    t_reset();
    t_byte();
    t_bit();
    t_timer();
    t_level();
    t_edge();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule